// File: doc/BRIEF.md
# PCM Test Pattern Generator

This block supplies a serial test stream for a PCM transmit path. During the transmit time slot of each frame it shifts out one 8-bit word at the bit rate. The bit rate is one quarter of the system clock: 2.048 Mbit/s from an 8.192 MHz clock. The fast clock retimes every bit, so the edges of the data line up with the bit clock and with the slot enable that other logic derives from the same counters.

There are two modes. In one-word mode a single programmable word is sent in every frame. In four-word mode the block cycles over four frames: first the programmable word, then three fixed marker words, each of which has exactly one bit set. A checker at the far end of a loopback can use the marker words to measure how many frames the path delays the data. A word-index output and a one-cycle cycle-start pulse, repeating at 2 kHz, show which word is in flight. The programmable word is set by eight active-low selectors. The mode and the word are taken up only at the boundary of a four-frame cycle.

Top module: `pcm_patgen`

## Requirements
- R1: After reset, `ser_out`, `word_idx` and `cyc_start` are 0. One-word mode is active and the programmable word is 10101001 until the first cycle boundary.
- R2: A loaded programmable word is the bitwise inverse of `word_sel_n`: a selector at 1 (closed) gives a data bit of 0.
- R3: The marker words are 00000001 at index 1, 10000000 at index 2 and 00010000 at index 3.
- R4: In one-word mode the programmable word is sent in every frame and `word_idx` stays 0.
- R5: In four-word mode each `frame_sync` moves the index forward by one. The order is 0, 1, 2, 3, and after 3 it returns to 0.
- R6: A `frame_sync` seen while the internal frame count is 3 ends a cycle. `cyc_start` is then 1 for exactly the next clock, and the frame count returns to 0.
- R7: When `slot_en` was 0 in a cycle, `ser_out` is 0 in the following cycle.
- R8: The word is sent leftmost bit first. While `slot_en` is 1, `ser_out` in the next cycle carries bit (7 − k) of the current word. Here k counts the `bit_phase` strobes seen since `slot_en` last rose, modulo 8. k returns to 0 whenever `slot_en` is 0.
- R9: Changes to `four_word` and `word_sel_n` take effect only at the cycle boundary of R6. Between boundaries the mode and the word in use stay unchanged.
- R10: `word_idx` gives the index of the word being sent. It is 0 in one-word mode and the frame count in four-word mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 8.192 MHz system clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_sync | input | 1 | One-cycle pulse at the start of each frame |
| slot_en | input | 1 | Transmit time-slot enable |
| bit_phase | input | 1 | One-cycle strobe in the last fast cycle of each bit period |
| four_word | input | 1 | 1 selects the four-word sequence, 0 selects one word |
| word_sel_n | input | 8 | Active-low selectors for the programmable word |
| ser_out | output | 1 | Retimed serial test data |
| word_idx | output | 2 | Index of the word in the current frame |
| cyc_start | output | 1 | One-cycle pulse when a new four-frame cycle begins |

## Verification
The hardest case to reach is a change of configuration in the middle of a cycle. The new word or mode must stay hidden for the remaining frames and then appear exactly when the cycle wraps. The stimulus therefore starts with selectors that differ from the reset default, so the first frames prove that the default is held. Later it switches mode and word at frames that are not cycle boundaries. Slot positions move from frame to frame, and one slot is cut short mid-word, which exercises the clearing of the bit counter.

// File: rtl/pcm_patgen_pkg.sv
package pcm_patgen_pkg;
   localparam int unsigned MARK_W = 8;

   // Fixed marker word for a sequence index (index 0 is the programmable word)
   function automatic logic [MARK_W-1:0] marker_word(input int unsigned idx);
      logic [MARK_W-1:0] w;
      case (idx)
         1:       w = 8'b0000_0001;
         2:       w = 8'b1000_0000;
         3:       w = 8'b0001_0000;
         default: w = '0;
      endcase
      return w;
   endfunction
endpackage

// File: rtl/pg_frame_seq.sv
module pg_frame_seq #(
   parameter int unsigned       SEQ_LEN       = 4,
   parameter int unsigned       WORD_W        = 8,
   parameter logic [WORD_W-1:0] DEFAULT_SEL_N = 8'b0101_0110,
   parameter bit                DEFAULT_FOUR  = 1'b0,
   localparam int unsigned      IDX_W         = $clog2(SEQ_LEN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_sync,
   input  logic              four_word,
   input  logic [WORD_W-1:0] word_sel_n,
   output logic [IDX_W-1:0]  word_idx,
   output logic [WORD_W-1:0] prog_word,
   output logic              cyc_start
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(SEQ_LEN - 1);

   logic [IDX_W-1:0] frame_cnt;
   logic             mode_q;
   logic             wrap;

   assign wrap = frame_sync && (frame_cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_cnt <= '0;
         mode_q    <= DEFAULT_FOUR;
         prog_word <= ~DEFAULT_SEL_N;
         cyc_start <= 1'b0;
      end else begin
         cyc_start <= wrap;
         if (wrap) begin
            frame_cnt <= '0;
            mode_q    <= four_word;
            prog_word <= ~word_sel_n;
         end else if (frame_sync) begin
            frame_cnt <= frame_cnt + 1'b1;
         end
      end
   end

   assign word_idx = mode_q ? frame_cnt : '0;

   AST_ONE_WORD_IDX: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_q |-> (word_idx == '0)); // R4

   AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_sync && mode_q && !wrap) |=> (word_idx == IDX_W'($past(word_idx) + 1'b1))); // R5

   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> ($stable(prog_word) && $stable(mode_q))); // R9

   AST_CYC_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_start |-> (word_idx == '0)); // R6
endmodule

// File: rtl/pg_word_sel.sv
module pg_word_sel #(
   parameter int unsigned  SEQ_LEN = 4,
   parameter int unsigned  WORD_W  = 8,
   localparam int unsigned IDX_W   = $clog2(SEQ_LEN)
) (
   input  logic [IDX_W-1:0]  word_idx,
   input  logic [WORD_W-1:0] prog_word,
   output logic [WORD_W-1:0] cur_word
);
   logic [WORD_W-1:0] table_w [SEQ_LEN];

   assign table_w[0] = prog_word;

   for (genvar g = 1; g < SEQ_LEN; g++) begin : g_marker
      assign table_w[g] = WORD_W'(pcm_patgen_pkg::marker_word(g));
   end

   assign cur_word = table_w[word_idx];
endmodule

// File: rtl/pg_serializer.sv
module pg_serializer #(
   parameter int unsigned  WORD_W    = 8,
   parameter bit           MSB_FIRST = 1'b1,
   localparam int unsigned CNT_W     = $clog2(WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slot_en,
   input  logic              bit_phase,
   input  logic [WORD_W-1:0] cur_word,
   output logic              ser_out
);
   localparam logic [CNT_W-1:0] TOP = CNT_W'(WORD_W - 1);

   logic [CNT_W-1:0] bit_cnt;
   logic [CNT_W-1:0] pick;

   if (MSB_FIRST) begin : g_msb
      assign pick = TOP - bit_cnt;
   end else begin : g_lsb
      assign pick = bit_cnt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         ser_out <= 1'b0;
      end else begin
         ser_out <= slot_en & cur_word[pick];
         if (!slot_en)
            bit_cnt <= '0;
         else if (bit_phase)
            bit_cnt <= bit_cnt + 1'b1;
      end
   end

   AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_en |=> !ser_out); // R7

   AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_en |=> (bit_cnt == '0)); // R8

   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_en && !bit_phase) |=> $stable(bit_cnt)); // R8
endmodule

// File: rtl/pcm_patgen.sv
module pcm_patgen #(
   parameter int unsigned       SEQ_LEN       = 4,
   parameter int unsigned       WORD_W        = 8,
   parameter logic [WORD_W-1:0] DEFAULT_SEL_N = 8'b0101_0110,
   parameter bit                DEFAULT_FOUR  = 1'b0,
   parameter bit                MSB_FIRST     = 1'b1,
   localparam int unsigned      IDX_W         = $clog2(SEQ_LEN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_sync,
   input  logic              slot_en,
   input  logic              bit_phase,
   input  logic              four_word,
   input  logic [WORD_W-1:0] word_sel_n,
   output logic              ser_out,
   output logic [IDX_W-1:0]  word_idx,
   output logic              cyc_start
);
   if (WORD_W != 8) begin : g_bad_width
      $error("pcm_patgen: WORD_W must be 8");
   end
   if (SEQ_LEN != 4) begin : g_bad_len
      $error("pcm_patgen: SEQ_LEN must be 4");
   end

   logic [WORD_W-1:0] prog_word;
   logic [WORD_W-1:0] cur_word;

   pg_frame_seq #(
      .SEQ_LEN      (SEQ_LEN),
      .WORD_W       (WORD_W),
      .DEFAULT_SEL_N(DEFAULT_SEL_N),
      .DEFAULT_FOUR (DEFAULT_FOUR)
   ) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_sync(frame_sync),
      .four_word (four_word),
      .word_sel_n(word_sel_n),
      .word_idx  (word_idx),
      .prog_word (prog_word),
      .cyc_start (cyc_start)
   );

   pg_word_sel #(
      .SEQ_LEN(SEQ_LEN),
      .WORD_W (WORD_W)
   ) sel_i (
      .word_idx (word_idx),
      .prog_word(prog_word),
      .cur_word (cur_word)
   );

   pg_serializer #(
      .WORD_W   (WORD_W),
      .MSB_FIRST(MSB_FIRST)
   ) ser_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .slot_en  (slot_en),
      .bit_phase(bit_phase),
      .cur_word (cur_word),
      .ser_out  (ser_out)
   );

   AST_MARKER_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
      (word_idx != '0) |-> ($countones(cur_word) == 1)); // R3

   AST_PROG_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (word_idx == '0) |-> (cur_word == prog_word)); // R2
endmodule

// File: tb/pcm_patgen_tb_top.sv
module pcm_patgen_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_sync = 1'b0;
   logic       slot_en = 1'b0;
   logic       bit_phase = 1'b0;
   logic       four_word = 1'b0;
   logic [7:0] word_sel_n = 8'hFF;
   logic       ser_out;
   logic [1:0] word_idx;
   logic       cyc_start;

   int checks = 0;
   int fails  = 0;

   // behavioural reference state
   int   m_fc = 0;
   bit   m_four = 1'b0;
   logic [7:0] m_word = 8'b1010_1001;
   int   m_k = 0;
   logic exp_ser = 1'b0;
   int   exp_idx = 0;
   logic exp_cyc = 1'b0;
   bit   exp_in_slot = 1'b0;
   string cur_tag = "R1";

   always #10 clk = ~clk;

   pcm_patgen dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_sync(frame_sync),
      .slot_en   (slot_en),
      .bit_phase (bit_phase),
      .four_word (four_word),
      .word_sel_n(word_sel_n),
      .ser_out   (ser_out),
      .word_idx  (word_idx),
      .cyc_start (cyc_start)
   );

   function automatic logic [7:0] ref_word(input int idx, input logic [7:0] w0);
      case (idx)
         0: return w0;
         1: return 8'b0000_0001;
         2: return 8'b1000_0000;
         default: return 8'b0001_0000;
      endcase
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // one clock: compare previous results, drive inputs, advance model
   task automatic step(input bit fs, input bit se, input bit bp);
      @(negedge clk);
      chk(exp_in_slot ? {cur_tag, "/R8"} : "R7", int'(ser_out), int'(exp_ser));
      chk("R10", int'(word_idx), exp_idx);
      chk("R6", int'(cyc_start), int'(exp_cyc));
      frame_sync = fs;
      slot_en    = se;
      bit_phase  = bp;
      begin
         logic [7:0] w;
         int idx_now;
         idx_now     = m_four ? m_fc : 0;
         w           = ref_word(idx_now, m_word);
         exp_in_slot = se;
         exp_ser     = se ? w[7 - m_k] : 1'b0;
         if (!se) m_k = 0;
         else if (bp) m_k = (m_k + 1) % 8;
         exp_cyc = fs && (m_fc == 3);
         if (fs && m_fc == 3) begin
            m_fc   = 0;
            m_four = four_word;
            m_word = ~word_sel_n;
         end else if (fs) begin
            m_fc = m_fc + 1;
         end
         exp_idx = m_four ? m_fc : 0;
      end
   endtask

   // one 64-cycle frame with a slot of length len starting at off
   task automatic frame(input int off, input int len);
      for (int c = 0; c < 64; c++) begin
         bit se;
         bit bp;
         se = (c >= off) && (c < off + len);
         bp = se ? (((c - off) % 4) == 3) : ((c % 4) == 3);
         step(c == 0, se, bp);
      end
   endtask

   initial begin
      #(20 * 100000);
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      chk("R1", int'(ser_out), 0);
      chk("R1", int'(word_idx), 0);
      chk("R1", int'(cyc_start), 0);
      rst_n = 1'b1;
      // selectors differ from default: default must hold until the boundary (R1, R9)
      word_sel_n = 8'hFF;
      cur_tag = "R1";
      for (int c = 0; c < 20; c++) step(1'b0, c >= 4 && c < 12, (c % 4) == 3);
      for (int f = 0; f < 3; f++) frame(1 + f * 7, 32);
      // wrap loads word 00000000; R2 with all selectors closed
      cur_tag = "R2";
      frame(5, 32);
      word_sel_n = 8'b0011_1100;           // gives 11000011
      cur_tag = "R9";
      for (int f = 0; f < 3; f++) frame(2 + f * 3, 32);
      cur_tag = "R2";
      frame(24, 32);
      // request four-word mode mid-cycle: must wait for the boundary (R9)
      four_word = 1'b1;
      cur_tag = "R9";
      for (int f = 0; f < 3; f++) frame(1 + f * 11, 32);
      cur_tag = "R5";
      for (int f = 0; f < 8; f++) frame(1 + (f * 5) % 24, 32);
      cur_tag = "R3";
      frame(7, 16);                        // short slot, bit counter cleared (R8)
      for (int f = 0; f < 3; f++) frame(3 + f, 32);
      // back to one-word mode with the default pattern
      four_word  = 1'b0;
      word_sel_n = 8'b0101_0110;
      cur_tag = "R9";
      for (int f = 0; f < 4; f++) frame(9, 32);
      cur_tag = "R4";
      for (int f = 0; f < 5; f++) frame(1 + f * 6, 32);
      step(1'b0, 1'b0, 1'b0);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule